// File: doc/BRIEF.md
# Two-Wire Clock Waveform Generator

This block produces the clock waveform for the master side of a two-wire serial bus. A configuration word holds three fields: a divider for the low phase, a divider for the high phase, and a power-of-two prescaler exponent. Each phase of the clock lasts `divider * 2^exponent + OFFSET` system clocks. `OFFSET` is a fixed parameter, normally 3 or 4. When both dividers are equal, the bus runs at `f_sys / (2 * (div * 2^exp + OFFSET))`. Settings cover standard-rate (100 kHz) and fast-rate (400 kHz) buses.

The block drives the bus clock line through an open-drain style output, `scl_pull_low`. It reads the line back on `scl_sense`, which must already be synchronised. The high phase counts only cycles in which the line is seen high. A slave that holds the clock low therefore stretches the high phase and does not shorten it. Two single-cycle strobes tell the bus engine when to act:
- `sda_change_stb` falls in the middle of the low phase, where the data line may change.
- `sda_sample_stb` falls in the middle of the high phase, where the data line is sampled.

Byte sequencing is left to the bus engine. All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake is needed.

Top module: `scl_wavegen`

## Requirements
- R1: While `rst_n` is low, or in the cycle after `run_en` is sampled low, `scl_pull_low`, `in_high_phase`, `sda_change_stb` and `sda_sample_stb` are all 0.
- R2: `scl_pull_low` rises at the first clock edge that samples `run_en` high. It stays high for exactly `lo_div * 2^exp + OFFSET` cycles.
- R3: After the low phase, the line is released for `hi_div * 2^exp + OFFSET` cycles in which `scl_sense` is sampled high. Then the next low phase starts.
- R4: `cfg_word` field positions are fixed:
  - bits 7:0 are the low-phase divider;
  - bits 15:8 are the high-phase divider;
  - bits 18:16 are the prescaler exponent.
- R5: An exponent above `MAX_EXP` (default 5) is treated as `MAX_EXP`, and both dividers are then forced to 255.
- R6: While in the high phase, cycles with `scl_sense` low do not advance the phase. The high phase is lengthened by exactly the number of such cycles.
- R7: `sda_change_stb` pulses exactly once per low phase, at cycle index `floor(low_len/2)`, counting the first low cycle as 0.
- R8: `sda_sample_stb` pulses exactly once per high phase. It fires on the high-sampled cycle whose count equals `floor(high_len/2)`, and never while `scl_sense` is low.
- R9: `cfg_word` is captured only when a low phase begins. A change during a period affects the following period only.
- R10: A divider of 0 gives a phase of exactly `OFFSET` cycles (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Generate the waveform while high; release the line while low |
| cfg_word | input | 19 | Low divider, high divider and prescaler exponent |
| scl_sense | input | 1 | Synchronised level of the bus clock line |
| scl_pull_low | output | 1 | 1 pulls the bus clock line low, 0 releases it |
| in_high_phase | output | 1 | High phase in progress, including stretch wait |
| sda_change_stb | output | 1 | Mid-low strobe: data line may change |
| sda_sample_stb | output | 1 | Mid-high strobe: data line is sampled |

## Verification
All outputs come from state registered on the rising edge. The bench therefore drives inputs and samples outputs on falling edges.

- **Enable:** a `run_en` set at one falling edge shows up as `scl_pull_low` high at the next falling edge. Dropping `run_en` clears every output by the falling edge that follows.
- **Phase lengths and strobes:** the bench counts consecutive falling-edge samples of `scl_pull_low` to get each phase length. It records the sample index at which each strobe appears and compares these with the formulas in R2, R3, R7 and R8.
- **Stretching and configuration changes:** stretch cycles and configuration swaps are applied at falling edges. Each one therefore takes effect at the very next rising edge, and the expected length is simply increased by the stretch count or moved to the next period.

// File: rtl/scl_wave_pkg.sv
package scl_wave_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // Width needed to hold the longest phase, in system clocks.
  function automatic int len_width(input int div_w, input int max_exp, input int offset);
    longint max_len;
    max_len = ((longint'(1) << div_w) - 1) * (longint'(1) << max_exp) + offset;
    return $clog2(max_len + 1);
  endfunction
endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode #(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int OFFSET  = 4,
  parameter int MAX_EXP = 5,
  parameter int LEN_W   = 13,
  localparam int CFG_W  = 2 * DIV_W + EXP_W
) (
  input  logic [CFG_W-1:0]            cfg,
  output logic [1:0][LEN_W-1:0]       phase_len   // [0] low, [1] high
);
  logic [EXP_W-1:0] exp_raw;
  logic             sat;
  logic [EXP_W-1:0] exp_eff;

  assign exp_raw = cfg[2*DIV_W +: EXP_W];
  assign sat     = (exp_raw > EXP_W'(MAX_EXP));
  assign exp_eff = sat ? EXP_W'(MAX_EXP) : exp_raw;

  for (genvar g = 0; g < 2; g++) begin : g_phase
    logic [DIV_W-1:0] div_eff;
    assign div_eff      = sat ? {DIV_W{1'b1}} : cfg[g*DIV_W +: DIV_W];
    assign phase_len[g] = (LEN_W'(div_eff) << exp_eff) + LEN_W'(OFFSET);
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_wave_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_en,
  input  logic                  scl_sense,
  input  logic [1:0][LEN_W-1:0] next_len,
  output scl_phase_e            phase,
  output logic [LEN_W-1:0]      cnt,
  output logic [LEN_W-1:0]      lo_len,
  output logic [LEN_W-1:0]      hi_len
);
  scl_phase_e       phase_q;
  logic [LEN_W-1:0] cnt_q, lo_len_q, hi_len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      lo_len_q <= '0;
      hi_len_q <= '0;
    end else if (!run_en) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_q  <= PH_LOW;
          cnt_q    <= '0;
          lo_len_q <= next_len[0];
          hi_len_q <= next_len[1];
        end
        PH_LOW: begin
          if (cnt_q == lo_len_q - LEN_W'(1)) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + LEN_W'(1);
          end
        end
        PH_HIGH: begin
          if (scl_sense) begin
            if (cnt_q == hi_len_q - LEN_W'(1)) begin
              phase_q  <= PH_LOW;
              cnt_q    <= '0;
              lo_len_q <= next_len[0];
              hi_len_q <= next_len[1];
            end else begin
              cnt_q <= cnt_q + LEN_W'(1);
            end
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase  = phase_q;
  assign cnt    = cnt_q;
  assign lo_len = lo_len_q;
  assign hi_len = hi_len_q;
endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
  import scl_wave_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  scl_phase_e       phase,
  input  logic [LEN_W-1:0] cnt,
  input  logic [LEN_W-1:0] lo_len,
  input  logic [LEN_W-1:0] hi_len,
  input  logic             scl_sense,
  output logic             chg_stb,
  output logic             smp_stb
);
  assign chg_stb = (phase == PH_LOW)  && (cnt == (lo_len >> 1));
  assign smp_stb = (phase == PH_HIGH) && scl_sense && (cnt == (hi_len >> 1));
endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
  import scl_wave_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int OFFSET  = 4,
  parameter int MAX_EXP = 5,
  localparam int CFG_W  = 2 * DIV_W + EXP_W,
  localparam int LEN_W  = len_width(DIV_W, MAX_EXP, OFFSET)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             scl_sense,
  output logic             scl_pull_low,
  output logic             in_high_phase,
  output logic             sda_change_stb,
  output logic             sda_sample_stb
);
  logic [1:0][LEN_W-1:0] next_len;
  scl_phase_e            phase;
  logic [LEN_W-1:0]      cnt, lo_len, hi_len;

  scl_cfg_decode #(
    .DIV_W(DIV_W), .EXP_W(EXP_W), .OFFSET(OFFSET), .MAX_EXP(MAX_EXP), .LEN_W(LEN_W)
  ) u_decode (
    .cfg       (cfg_word),
    .phase_len (next_len)
  );

  scl_phase_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .scl_sense (scl_sense),
    .next_len  (next_len),
    .phase     (phase),
    .cnt       (cnt),
    .lo_len    (lo_len),
    .hi_len    (hi_len)
  );

  scl_strobe_gen #(.LEN_W(LEN_W)) u_stb (
    .phase     (phase),
    .cnt       (cnt),
    .lo_len    (lo_len),
    .hi_len    (hi_len),
    .scl_sense (scl_sense),
    .chg_stb   (sda_change_stb),
    .smp_stb   (sda_sample_stb)
  );

  assign scl_pull_low  = (phase == PH_LOW);
  assign in_high_phase = (phase == PH_HIGH);
endmodule

// File: rtl/scl_wavegen_chk.sv
module scl_wavegen_chk #(
  parameter int DIV_W   = 8,
  parameter int OFFSET  = 4,
  parameter int MAX_EXP = 5,
  localparam int MAX_LEN = (2**DIV_W - 1) * (2**MAX_EXP) + OFFSET
) (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic scl_sense,
  input logic scl_pull_low,
  input logic in_high_phase,
  input logic sda_change_stb,
  input logic sda_sample_stb
);
  int lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !scl_pull_low) lo_run <= 0;
    else                         lo_run <= lo_run + 1;
  end

  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!scl_pull_low && !in_high_phase && !sda_change_stb && !sda_sample_stb));

  assert_low_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_low |-> (lo_run < MAX_LEN));

  assert_stretch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_high_phase && !scl_sense && run_en) |=> in_high_phase);

  assert_change_in_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change_stb |-> (scl_pull_low && $onehot0({sda_change_stb, sda_sample_stb})));

  assert_sample_bus_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample_stb |-> (scl_sense && in_high_phase && !scl_pull_low));
endmodule

bind scl_wavegen scl_wavegen_chk #(
  .DIV_W(DIV_W), .OFFSET(OFFSET), .MAX_EXP(MAX_EXP)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .run_en         (run_en),
  .scl_sense      (scl_sense),
  .scl_pull_low   (scl_pull_low),
  .in_high_phase  (in_high_phase),
  .sda_change_stb (sda_change_stb),
  .sda_sample_stb (sda_sample_stb)
);

// File: tb/test_scl_wavegen.sv
module test_scl_wavegen;
  localparam int CLK_PERIOD = 10;
  localparam int OFFSET     = 4;
  localparam int MAX_EXP    = 5;
  localparam int CFG_W      = 19;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic [CFG_W-1:0] cfg_word = '0;
  logic stretch = 1'b0;
  logic scl_sense;
  logic scl_pull_low, in_high_phase, sda_change_stb, sda_sample_stb;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain bus: released line reads high unless a slave stretches
  assign scl_sense = ~(scl_pull_low | stretch);

  scl_wavegen #(.OFFSET(OFFSET), .MAX_EXP(MAX_EXP)) i_scl_wavegen (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_en         (run_en),
    .cfg_word       (cfg_word),
    .scl_sense      (scl_sense),
    .scl_pull_low   (scl_pull_low),
    .in_high_phase  (in_high_phase),
    .sda_change_stb (sda_change_stb),
    .sda_sample_stb (sda_sample_stb)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [CFG_W-1:0] mk(input int lo, input int hi, input int e);
    return {3'(e), 8'(hi), 8'(lo)};
  endfunction

  function automatic int plen(input int div, input int e);
    if (e > MAX_EXP) return 255 * (1 << MAX_EXP) + OFFSET;
    return div * (1 << e) + OFFSET;
  endfunction

  task automatic start(input logic [CFG_W-1:0] c);
    @(negedge clk);
    run_en = 1'b0;
    cfg_word = c;
    @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
  endtask

  // Measures one full period starting at a falling edge where the low phase runs.
  task automatic measure(input int s, input bit swap, input logic [CFG_W-1:0] swap_cfg,
                         output int lo, output int hi, output int chg_at, output int smp_at,
                         output int chg_n, output int smp_n);
    int i, j;
    lo = 0; hi = 0; chg_at = -1; smp_at = -1; chg_n = 0; smp_n = 0;
    while (!scl_pull_low) @(negedge clk);
    i = 0;
    while (scl_pull_low) begin
      if (sda_change_stb) begin chg_at = i; chg_n++; end
      if (sda_sample_stb) smp_n++;
      if (swap && i == 1) cfg_word = swap_cfg;
      i++;
      @(negedge clk);
    end
    lo = i;
    j = 0;
    while (!scl_pull_low) begin
      stretch = (j < s);
      #1;
      if (sda_sample_stb) begin smp_at = j; smp_n++; end
      if (sda_change_stb) chg_n++;
      j++;
      @(negedge clk);
    end
    stretch = 1'b0;
    hi = j;
  endtask

  task automatic period_check(input string tag, input int lo_div, input int hi_div,
                              input int e, input int s);
    int lo, hi, ca, sa, cn, sn, el, eh;
    el = plen(lo_div, e);
    eh = plen(hi_div, e);
    measure(s, 1'b0, '0, lo, hi, ca, sa, cn, sn);
    chk({tag, " low length"}, lo, el);
    chk({tag, " high length"}, hi, eh + s);
    chk({tag, " R7 change strobe index"}, ca, el / 2);
    chk({tag, " R7 change strobe count"}, cn, 1);
    chk({tag, " R8 sample strobe index"}, sa, s + eh / 2);
    chk({tag, " R8 sample strobe count"}, sn, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset pull_low", int'(scl_pull_low), 0);
    chk("R1 reset high_phase", int'(in_high_phase), 0);
    chk("R1 reset strobes", int'(sda_change_stb | sda_sample_stb), 0);
  endtask

  task automatic t_symmetric;
    start(mk(2, 2, 0));
    chk("R2 low starts one edge after enable", int'(scl_pull_low), 1);
    period_check("R2 R3 symmetric", 2, 2, 0, 0);
    period_check("R3 second period", 2, 2, 0, 0);
  endtask

  task automatic t_asym_fields;
    start(mk(5, 1, 2));
    period_check("R4 asymmetric fields", 5, 1, 2, 0);
  endtask

  task automatic t_zero_div;
    start(mk(0, 0, 3));
    period_check("R10 zero dividers", 0, 0, 3, 0);
  endtask

  task automatic t_max_exp_exact;
    start(mk(1, 3, MAX_EXP));
    period_check("R5 exponent at max", 1, 3, MAX_EXP, 0);
  endtask

  task automatic t_saturate;
    start(mk(1, 2, 7));
    period_check("R5 saturated exponent", 1, 2, 7, 0);
  endtask

  task automatic t_stretch;
    start(mk(3, 3, 0));
    period_check("R6 stretched high", 3, 3, 0, 10);
    period_check("R6 unstretched after", 3, 3, 0, 0);
  endtask

  task automatic t_cfg_latch;
    int lo, hi, ca, sa, cn, sn;
    start(mk(2, 2, 0));
    measure(0, 1'b1, mk(4, 0, 1), lo, hi, ca, sa, cn, sn);
    chk("R9 low unchanged in current period", lo, plen(2, 0));
    chk("R9 high unchanged in current period", hi, plen(2, 0));
    measure(0, 1'b0, '0, lo, hi, ca, sa, cn, sn);
    chk("R9 low uses new config", lo, plen(4, 1));
    chk("R9 high uses new config", hi, plen(0, 1));
  endtask

  task automatic t_disable;
    start(mk(6, 6, 0));
    repeat (3) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    chk("R1 disable releases line", int'(scl_pull_low), 0);
    chk("R1 disable high_phase", int'(in_high_phase), 0);
    repeat (5) begin
      @(negedge clk);
      chk("R1 idle strobes", int'(sda_change_stb | sda_sample_stb), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_symmetric();
    t_asym_fields();
    t_zero_div();
    t_max_exp_exact();
    t_saturate();
    t_stretch();
    t_cfg_latch();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule